// File: doc/BRIEF.md
# Hub Power-Up Boot Sequencer

This block steps a hub controller from power-on reset through configuration into an operating stage. While reset is held it stays in standby. Once reset is released it waits in a hardware bring-up stage until the regulator, the PLL and the reference clock are all ready. It latches the configuration-select strap during that stage. It then picks how the configuration is obtained: a load from an external ROM, an open-ended configuration session driven by a host SoC over the management bus, or plain defaults.

To find out whether a management bus is present, the sequencer turns on weak pull-downs on both bus lines for a fixed window. If both lines still read high at the end of the window, stronger external pull-ups must be present. The SoC session has no time limit and ends only on a write to the terminating register address. When the configuration merge reports done, the sequencer goes to charger detection, to connect, or through idle into suspend. The choice depends on VBUS and on the charging enable.

The current stage is reported as a one-hot vector. The block also drives the probe pull-downs, a request for the external ROM load, and a flag that grants register access.

Top module: `hub_boot_seq`

## Requirements
- R1: While rstN is low, stageOneHot shows only bit 0 (standby) and pullDownEn, romLoadReq and regAccessOk are low. Asserting reset at any stage returns the block to standby and clears the latched strap.
- R2: The first clock edge after reset release enters hardware-init (bit 1). Hardware-init moves to software-init (bit 2) only on an edge where regGood, pllLock and refClkOk are all high.
- R3: The cfgSel strap is sampled on every edge spent in hardware-init. Changes to cfgSel after hardware-init has been left have no effect on the path taken.
- R4: With a latched strap of 2'b01, software-init goes on the next edge to the configuration stage (bit 5). romLoadReq is high for the whole configuration stage, and no probe takes place.
- R5: With any other strap, software-init goes to the probe stage (bit 3). pullDownEn is high for exactly 16 cycles and drops on the edge that ends the probe.
- R6: At the end of the probe, the block enters SoC-configuration (bit 4) if sdaIn and sclIn are both high. Otherwise it enters the configuration stage with romLoadReq low.
- R7: regAccessOk is high only in SoC-configuration. In hardware-init it is low, and a write there, even to address 0xFF, changes nothing.
- R8: SoC-configuration holds for any number of cycles. It leaves, to the configuration stage, only on an edge with regWrEn high and regAddr equal to 0xFF. Writes to other addresses are ignored.
- R9: The configuration stage holds until mergeDone. On that edge it goes to charger detection (bit 8) if vbusOn and chgEnable are both high. It goes to connect (bit 9) if vbusOn is high and chgEnable is low. If vbusOn is low it goes to idle (bit 6), and one cycle later to suspend (bit 7).
- R10: Suspend holds while vbusOn is low. When vbusOn rises, suspend goes to charger detection if chgEnable is high, and to connect otherwise.
- R11: Exactly one bit of stageOneHot is set at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset; standby while low |
| regGood | input | 1 | Core regulator is stable |
| pllLock | input | 1 | PLL is locked |
| refClkOk | input | 1 | Reference clock is present |
| cfgSel | input | 2 | Configuration-select strap |
| sdaIn | input | 1 | Sampled data line level |
| sclIn | input | 1 | Sampled clock line level |
| regWrEn | input | 1 | Register write strobe from the management bus |
| regAddr | input | 8 | Register address of the write |
| mergeDone | input | 1 | Configuration merge has finished |
| vbusOn | input | 1 | VBUS is present |
| chgEnable | input | 1 | Upstream battery-charging detection is enabled |
| stageOneHot | output | 10 | One-hot stage: 0 standby, 1 hw-init, 2 sw-init, 3 probe, 4 SoC-config, 5 config, 6 idle, 7 suspend, 8 charger detect, 9 connect |
| pullDownEn | output | 1 | Enables the weak pull-downs on both bus lines |
| romLoadReq | output | 1 | Requests a configuration load from the external ROM |
| regAccessOk | output | 1 | Register access over the management bus is allowed |

## Verification
A table of boots crosses each strap class with the line levels seen at the end of the probe and with the VBUS and charging settings. The ROM strap is thus told apart from the probed straps, a detected bus from a single high line or none, and the three exit routes from one another. Directed boots hold back each readiness flag in turn. They move the strap after it should have frozen and write to the terminating address outside the SoC session. They also stall the SoC session for a long time with writes to other addresses, bring VBUS up during suspend, and assert reset partway through a boot.

// File: rtl/hub_boot_pkg.sv
package hub_boot_pkg;

  typedef enum logic [3:0] {
    STG_STANDBY = 4'd0,
    STG_HWINIT  = 4'd1,
    STG_SWINIT  = 4'd2,
    STG_PROBE   = 4'd3,
    STG_SOCCFG  = 4'd4,
    STG_CONFIG  = 4'd5,
    STG_IDLE    = 4'd6,
    STG_SUSPEND = 4'd7,
    STG_CHGDET  = 4'd8,
    STG_CONNECT = 4'd9
  } stage_t;

  localparam int NUM_STAGES = 10;

  typedef struct packed {
    logic latchStrap;
    logic clrProbe;
    logic runProbe;
  } dpStrobe_t;

endpackage

// File: rtl/hub_boot_dp.sv
module hub_boot_dp
  import hub_boot_pkg::*;
#(
  parameter int PROBE_CYCLES = 16,
  parameter logic [1:0] ROM_STRAP = 2'b01
) (
  input  logic      clk,
  input  logic      rstN,
  input  dpStrobe_t stb,
  input  logic [1:0] cfgSel,
  input  logic      sdaIn,
  input  logic      sclIn,
  output logic      probeDone,
  output logic      busSeen,
  output logic      strapRom
);
  localparam int CNT_W = $clog2(PROBE_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(PROBE_CYCLES - 1);

  logic [1:0]       strapQ;
  logic [CNT_W-1:0] probeCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      strapQ <= 2'b00;
    end else if (stb.latchStrap) begin
      strapQ <= cfgSel;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      probeCnt <= '0;
    end else if (stb.clrProbe) begin
      probeCnt <= '0;
    end else if (stb.runProbe && probeCnt != LAST_CNT) begin
      probeCnt <= probeCnt + 1'b1;
    end
  end

  assign probeDone = (probeCnt == LAST_CNT);
  assign busSeen   = sdaIn & sclIn;
  assign strapRom  = (strapQ == ROM_STRAP);

  AST_STRAP_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    !stb.latchStrap |=> $stable(strapQ)) else $error("strap moved"); // R3

  AST_PROBE_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    probeCnt <= LAST_CNT) else $error("probe count overrun"); // R5

endmodule

// File: rtl/hub_boot_ctrl.sv
module hub_boot_ctrl
  import hub_boot_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] END_ADDR = 8'hFF
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regGood,
  input  logic              pllLock,
  input  logic              refClkOk,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              mergeDone,
  input  logic              vbusOn,
  input  logic              chgEnable,
  input  logic              probeDone,
  input  logic              busSeen,
  input  logic              strapRom,
  output stage_t            stage,
  output dpStrobe_t         stb
);
  stage_t stageNext;
  logic   hwReady;
  logic   endWrite;

  assign hwReady  = regGood & pllLock & refClkOk;
  assign endWrite = regWrEn && (regAddr == END_ADDR);

  always_comb begin
    stageNext = stage;
    unique case (stage)
      STG_STANDBY: stageNext = STG_HWINIT;
      STG_HWINIT:  if (hwReady) stageNext = STG_SWINIT;
      STG_SWINIT:  stageNext = strapRom ? STG_CONFIG : STG_PROBE;
      STG_PROBE:   if (probeDone) stageNext = busSeen ? STG_SOCCFG : STG_CONFIG;
      STG_SOCCFG:  if (endWrite) stageNext = STG_CONFIG;
      STG_CONFIG: begin
        if (mergeDone) begin
          if (!vbusOn)        stageNext = STG_IDLE;
          else if (chgEnable) stageNext = STG_CHGDET;
          else                stageNext = STG_CONNECT;
        end
      end
      STG_IDLE:    stageNext = STG_SUSPEND;
      STG_SUSPEND: if (vbusOn) stageNext = chgEnable ? STG_CHGDET : STG_CONNECT;
      STG_CHGDET:  stageNext = STG_CHGDET;
      STG_CONNECT: stageNext = STG_CONNECT;
      default:     stageNext = STG_STANDBY;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stage <= STG_STANDBY;
    else       stage <= stageNext;
  end

  always_comb begin
    stb.latchStrap = (stage == STG_HWINIT);
    stb.clrProbe   = (stage == STG_SWINIT);
    stb.runProbe   = (stage == STG_PROBE);
  end

  AST_HW_WAIT: assert property (@(posedge clk) disable iff (!rstN)
    (stage == STG_HWINIT && !hwReady) |=> stage == STG_HWINIT) else $error("hw-init left early"); // R2

  AST_PROBE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (stage == STG_PROBE && !probeDone) |=> stage == STG_PROBE) else $error("probe cut short"); // R5

  AST_SOC_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (stage == STG_SOCCFG && !endWrite) |=> stage == STG_SOCCFG) else $error("soc session left"); // R8

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (stage == STG_CONFIG && !mergeDone) |=> stage == STG_CONFIG) else $error("config left early"); // R9

  AST_SUSPEND_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (stage == STG_SUSPEND && !vbusOn) |=> stage == STG_SUSPEND) else $error("suspend left"); // R10

endmodule

// File: rtl/hub_boot_seq.sv
module hub_boot_seq
  import hub_boot_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] END_ADDR = 8'hFF,
  parameter int PROBE_CYCLES = 16,
  parameter logic [1:0] ROM_STRAP = 2'b01
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regGood,
  input  logic              pllLock,
  input  logic              refClkOk,
  input  logic [1:0]        cfgSel,
  input  logic              sdaIn,
  input  logic              sclIn,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              mergeDone,
  input  logic              vbusOn,
  input  logic              chgEnable,
  output logic [NUM_STAGES-1:0] stageOneHot,
  output logic              pullDownEn,
  output logic              romLoadReq,
  output logic              regAccessOk
);
  stage_t    stage;
  dpStrobe_t stb;
  logic      probeDone;
  logic      busSeen;
  logic      strapRom;

  hub_boot_ctrl #(.ADDR_W(ADDR_W), .END_ADDR(END_ADDR)) u_ctrl (
    .clk(clk), .rstN(rstN), .regGood(regGood), .pllLock(pllLock),
    .refClkOk(refClkOk), .regWrEn(regWrEn), .regAddr(regAddr),
    .mergeDone(mergeDone), .vbusOn(vbusOn), .chgEnable(chgEnable),
    .probeDone(probeDone), .busSeen(busSeen), .strapRom(strapRom),
    .stage(stage), .stb(stb)
  );

  hub_boot_dp #(.PROBE_CYCLES(PROBE_CYCLES), .ROM_STRAP(ROM_STRAP)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .cfgSel(cfgSel),
    .sdaIn(sdaIn), .sclIn(sclIn), .probeDone(probeDone),
    .busSeen(busSeen), .strapRom(strapRom)
  );

  for (genvar g = 0; g < NUM_STAGES; g++) begin : g_onehot
    assign stageOneHot[g] = (stage == stage_t'(g));
  end

  assign pullDownEn  = (stage == STG_PROBE);
  assign regAccessOk = (stage == STG_SOCCFG);
  assign romLoadReq  = (stage == STG_CONFIG) && strapRom;

  AST_ONE_STAGE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot(stageOneHot)) else $error("stage not one-hot"); // R11

  AST_PD_ENDS: assert property (@(posedge clk) disable iff (!rstN)
    (pullDownEn && probeDone) |=> !pullDownEn) else $error("pull-downs held"); // R5

  AST_ROM_NO_PROBE: assert property (@(posedge clk) disable iff (!rstN)
    romLoadReq |-> !$past(pullDownEn)) else $error("rom after probe"); // R4

endmodule

// File: tb/hub_boot_seq_bench.sv
module hub_boot_seq_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regGood = 1'b0, pllLock = 1'b0, refClkOk = 1'b0;
  logic [1:0] cfgSel = 2'b00;
  logic sdaIn = 1'b0, sclIn = 1'b0;
  logic regWrEn = 1'b0;
  logic [7:0] regAddr = 8'h00;
  logic mergeDone = 1'b0, vbusOn = 1'b0, chgEnable = 1'b0;
  logic [9:0] stageOneHot;
  logic pullDownEn, romLoadReq, regAccessOk;

  int checks = 0;
  int failures = 0;

  localparam int B_STANDBY = 0, B_HWINIT = 1, B_SWINIT = 2, B_PROBE = 3, B_SOCCFG = 4,
                 B_CONFIG = 5, B_IDLE = 6, B_SUSPEND = 7, B_CHGDET = 8, B_CONNECT = 9;

  // {cfgSel[1:0], sdaIn, sclIn, vbusOn, chgEnable}
  localparam int NVEC = 7;
  localparam logic [5:0] VECS [NVEC] = '{
    6'b01_11_11, 6'b00_11_10, 6'b10_01_11, 6'b11_10_00,
    6'b00_00_10, 6'b11_11_01, 6'b01_00_00
  };

  always #5 clk = ~clk;

  hub_boot_seq u_hub_boot_seq (
    .clk(clk), .rstN(rstN), .regGood(regGood), .pllLock(pllLock), .refClkOk(refClkOk),
    .cfgSel(cfgSel), .sdaIn(sdaIn), .sclIn(sclIn), .regWrEn(regWrEn), .regAddr(regAddr),
    .mergeDone(mergeDone), .vbusOn(vbusOn), .chgEnable(chgEnable),
    .stageOneHot(stageOneHot), .pullDownEn(pullDownEn), .romLoadReq(romLoadReq),
    .regAccessOk(regAccessOk)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chkStage(input string req, input int bitPos);
    chk(req, int'(stageOneHot), 1 << bitPos);
  endtask

  task automatic doReset();
    rstN = 1'b0;
    regWrEn = 1'b0; mergeDone = 1'b0;
    tick();
  endtask

  task automatic runBoot(input logic [5:0] v);
    logic expRom, expSoc;
    doReset();
    chkStage("R1 standby", B_STANDBY);
    cfgSel = v[5:4]; sdaIn = v[3]; sclIn = v[2]; vbusOn = v[1]; chgEnable = v[0];
    regGood = 1'b1; pllLock = 1'b1; refClkOk = 1'b1;
    expRom = (v[5:4] == 2'b01);
    expSoc = !expRom && v[3] && v[2];
    rstN = 1'b1;
    tick(); chkStage("R2 hwinit", B_HWINIT);
    tick(); chkStage("R2 swinit", B_SWINIT);
    tick();
    if (expRom) begin
      chkStage("R4 rom to config", B_CONFIG);
      chk("R4 rom request", int'(romLoadReq), 1);
    end else begin
      chkStage("R5 probe", B_PROBE);
      for (int i = 0; i < 15; i++) begin
        chk("R5 pulldown on", int'(pullDownEn), 1);
        tick();
      end
      chk("R5 pulldown last", int'(pullDownEn), 1);
      tick();
      chk("R5 pulldown off", int'(pullDownEn), 0);
      chkStage("R6 probe result", expSoc ? B_SOCCFG : B_CONFIG);
      if (expSoc) begin
        chk("R7 access in soc", int'(regAccessOk), 1);
        regWrEn = 1'b1; regAddr = 8'h3C;
        tick(); chkStage("R8 other address", B_SOCCFG);
        regAddr = 8'hFF;
        tick(); regWrEn = 1'b0;
        chkStage("R8 end write", B_CONFIG);
      end
      chk("R6 no rom", int'(romLoadReq), 0);
    end
    chk("R7 no access in config", int'(regAccessOk), 0);
    tick(); chkStage("R9 config holds", B_CONFIG);
    mergeDone = 1'b1;
    tick(); mergeDone = 1'b0;
    if (!v[1]) begin
      chkStage("R9 idle", B_IDLE);
      tick(); chkStage("R9 suspend", B_SUSPEND);
    end else begin
      chkStage("R9 route", v[0] ? B_CHGDET : B_CONNECT);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #2;
    chkStage("R1 reset stage", B_STANDBY);
    chk("R1 outputs low", int'({pullDownEn, romLoadReq, regAccessOk}), 0);

    for (int k = 0; k < NVEC; k++) runBoot(VECS[k]);

    // R2: each readiness flag missing holds hw-init; R7: write in hw-init ignored
    for (int m = 0; m < 3; m++) begin
      doReset();
      regGood = (m != 0); pllLock = (m != 1); refClkOk = (m != 2);
      rstN = 1'b1;
      tick(); chkStage("R2 enter hwinit", B_HWINIT);
      chk("R7 no access hwinit", int'(regAccessOk), 0);
      regWrEn = 1'b1; regAddr = 8'hFF;
      for (int i = 0; i < 5; i++) tick();
      regWrEn = 1'b0;
      chkStage("R2 R7 hwinit waits", B_HWINIT);
      regGood = 1'b1; pllLock = 1'b1; refClkOk = 1'b1;
      tick(); chkStage("R2 released", B_SWINIT);
    end

    // R3: strap moved after hw-init has no effect
    doReset();
    cfgSel = 2'b00; sdaIn = 1'b1; sclIn = 1'b1;
    rstN = 1'b1;
    tick(); tick();
    chkStage("R3 swinit", B_SWINIT);
    cfgSel = 2'b01;
    tick(); chkStage("R3 strap frozen", B_PROBE);
    chk("R3 no rom", int'(romLoadReq), 0);
    for (int i = 0; i < 16; i++) tick();
    chkStage("R6 soc reached", B_SOCCFG);

    // R8: long wait in soc session with stray writes
    for (int i = 0; i < 300; i++) begin
      regWrEn = (i % 7 == 0); regAddr = 8'(i % 255);
      tick();
    end
    regWrEn = 1'b0;
    chkStage("R8 still waiting", B_SOCCFG);

    // R1: reset mid-session, strap cleared
    rstN = 1'b0;
    #1;
    chkStage("R1 async standby", B_STANDBY);
    chk("R1 outputs cleared", int'({pullDownEn, romLoadReq, regAccessOk}), 0);

    // R10: suspend left when vbus appears
    runBoot(6'b00_00_01);
    tick(); chkStage("R10 suspend holds", B_SUSPEND);
    vbusOn = 1'b1; chgEnable = 1'b1;
    tick(); chkStage("R10 to chgdet", B_CHGDET);
    runBoot(6'b10_00_00);
    vbusOn = 1'b1; chgEnable = 1'b0;
    tick(); chkStage("R10 to connect", B_CONNECT);
    tick(); chk("R11 one stage", $countones(stageOneHot), 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule